// File: doc/BRIEF.md
# SD Data Block CRC Unit

This unit guards data blocks that cross a single-wire SD/MMC data line with a CRC16, in either direction. When a block arrives from the card, the unit runs a CRC16 over the payload bits and compares the result, bit by bit, with the check bits that follow the payload. When a block goes out to the card, the unit forwards the payload, appends its own check bits, and then waits for the card's 3-bit status token. It decodes the token as an accept or a reject.

In double-data-rate operation the line carries two interleaved bit streams: one sampled on the rising clock edge and one on the falling edge. The unit keeps a separate CRC16 register for each stream, so that each stream is checked or protected on its own. The line bits reach the unit as a sequence of slots qualified by a valid strobe, and the slots alternate between the rising and falling streams. A failed block of either kind sets a sticky error flag. The flag drives an interrupt request that can be masked, and a strobe clears it.

Top module: `sdcrc_unit`

## Requirements
- R1: In single-rate mode, a read block is `blk_bytes`*8 payload bits (each byte sent most significant bit first), followed by 16 check bits. The unit computes CRC16 over the payload, with polynomial x^16+x^12+x^5+1 (0x1021) and an all-zero start value. It compares the result, most significant bit first, with the check bits. It then pulses `blk_done`, and pulses `blk_fail` with it if any check bit differs. Only slots with `rx_vld` high count.
- R2: In double-rate mode, payload slots 0, 2, 4, … feed the rising-edge CRC and slots 1, 3, 5, … feed the falling-edge CRC. The payload is followed by 32 check bits interleaved as rising bit 15, falling bit 15, rising bit 14, and so on. A mismatch in either lane fails the block.
- R3: On a write, each accepted `wr_bit` appears on `tx_bit` with `tx_vld` high one cycle later. The payload is followed on consecutive cycles by the check bits, in the same layout as R1 (16 bits) or R2 (32 interleaved bits).
- R4: After the write check bits, the unit ignores line bits of 1 until a start bit of 0 arrives. It then takes 3 status bits, most significant first, and an end bit. Status 010 with an end bit of 1 passes the block. Any other status or end bit fails it.
- R5: `crc_err` is set by every failed block, in the same cycle as the `blk_fail` pulse. It stays set through later good blocks until `clr_err` is pulsed.
- R6: `irq` follows `crc_err` AND `irq_en`, one cycle later. It stays low whenever `irq_en` is low.
- R7: `start_rd` and `start_wr` are ignored while `busy` is high. `blk_bytes` and `ddr_mode` are captured only when a block starts. `blk_bytes` must be between 1 and MAX_BYTES.
- R8: After reset, `busy`, `tx_vld`, `blk_done`, `blk_fail`, `crc_err` and `irq` are all low.
- R9: `blk_done` is a single-cycle pulse, once per block, and `blk_fail` is high only together with `blk_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_rd | input | 1 | Begin a read block (ignored while busy) |
| start_wr | input | 1 | Begin a write block (ignored while busy) |
| ddr_mode | input | 1 | 1 = two interleaved CRC lanes, 0 = single lane |
| blk_bytes | input | BYTES_W | Payload length in bytes, captured at start |
| rx_vld | input | 1 | Qualifies a line bit arriving from the card |
| rx_bit | input | 1 | Line bit from the card (read payload, check bits, token) |
| wr_vld | input | 1 | Qualifies a write payload bit |
| wr_bit | input | 1 | Write payload bit |
| clr_err | input | 1 | Clears the sticky error flag |
| irq_en | input | 1 | Enables the interrupt request |
| tx_vld | output | 1 | Qualifies a bit sent toward the card |
| tx_bit | output | 1 | Outgoing payload or check bit |
| busy | output | 1 | A block is in progress |
| blk_done | output | 1 | One-cycle pulse when a block completes |
| blk_fail | output | 1 | Pulses with blk_done when the block failed |
| crc_err | output | 1 | Sticky data CRC error flag |
| irq | output | 1 | Masked interrupt request |

## Verification
The in-RTL assertions check the timing of the status signals on every cycle. They cover the single-cycle completion pulse, a fail pulse that never appears without it, the sticky flag, the interrupt mask, outgoing data appearing only inside a block, and a legal length at start. The CRC arithmetic itself can only be shown by the bench scenarios, which compare against an independent CRC model. These scenarios cover lane interleaving and token decoding in double-rate mode, tokens preceded by idle ones, gaps in the valid strobes, and start requests made while a block is in flight.

// File: rtl/sdcrc_pkg.sv
package sdcrc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_DATA,
    ST_RD_CRC,
    ST_WR_DATA,
    ST_WR_CRC,
    ST_WR_TOK
  } blk_state_e;

  typedef enum logic [1:0] {
    LOP_HOLD,
    LOP_INIT,
    LOP_FEED,
    LOP_SHIFT
  } lane_op_e;

  typedef enum logic [1:0] {
    TK_WAIT,
    TK_BITS,
    TK_END
  } tok_state_e;

endpackage

// File: rtl/sdcrc_lane.sv
module sdcrc_lane
  import sdcrc_pkg::*;
#(
  parameter int                 CRC_W = 16,
  parameter logic [CRC_W-1:0]   POLY  = 'h1021
) (
  input  logic     clk,
  input  logic     rst,
  input  lane_op_e op,
  input  logic     din,
  output logic     msb
);

  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      crc_q <= '0;
    end else begin
      case (op)
        LOP_INIT:  crc_q <= '0;
        LOP_FEED:  crc_q <= {crc_q[CRC_W-2:0], 1'b0} ^
                            ((crc_q[CRC_W-1] ^ din) ? POLY : '0);
        LOP_SHIFT: crc_q <= {crc_q[CRC_W-2:0], 1'b0};
        default:   crc_q <= crc_q;
      endcase
    end
  end

  assign msb = crc_q[CRC_W-1];

endmodule

// File: rtl/sdcrc_tok.sv
module sdcrc_tok
  import sdcrc_pkg::*;
#(
  parameter int               TOK_W = 3,
  parameter logic [TOK_W-1:0] GOOD  = 3'b010
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic vld,
  input  logic bit_in,
  output logic done,
  output logic good
);

  localparam int CW = $clog2(TOK_W + 1);

  tok_state_e       st_q;
  logic [CW-1:0]    cnt_q;
  logic [TOK_W-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= TK_WAIT;
      cnt_q <= '0;
      sh_q  <= '0;
      done  <= 1'b0;
      good  <= 1'b0;
    end else if (!en) begin
      st_q  <= TK_WAIT;
      cnt_q <= '0;
      done  <= 1'b0;
      good  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (vld) begin
        case (st_q)
          TK_WAIT: begin
            if (!bit_in) begin
              st_q  <= TK_BITS;
              cnt_q <= '0;
            end
          end
          TK_BITS: begin
            sh_q <= {sh_q[TOK_W-2:0], bit_in};
            if (cnt_q == CW'(TOK_W - 1)) st_q <= TK_END;
            else                         cnt_q <= cnt_q + 1'b1;
          end
          TK_END: begin
            done <= 1'b1;
            good <= (sh_q == GOOD) && bit_in;
            st_q <= TK_WAIT;
          end
          default: st_q <= TK_WAIT;
        endcase
      end
    end
  end

  AST_TOK_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R4

endmodule

// File: rtl/sdcrc_unit.sv
module sdcrc_unit
  import sdcrc_pkg::*;
#(
  parameter int                 MAX_BYTES = 512,
  parameter int                 CRC_W     = 16,
  parameter logic [CRC_W-1:0]   CRC_POLY  = 'h1021,
  parameter int                 TOK_W     = 3,
  parameter logic [TOK_W-1:0]   TOK_GOOD  = 3'b010,
  localparam int                BYTES_W   = $clog2(MAX_BYTES + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_rd,
  input  logic               start_wr,
  input  logic               ddr_mode,
  input  logic [BYTES_W-1:0] blk_bytes,
  input  logic               rx_vld,
  input  logic               rx_bit,
  input  logic               wr_vld,
  input  logic               wr_bit,
  input  logic               clr_err,
  input  logic               irq_en,
  output logic               tx_vld,
  output logic               tx_bit,
  output logic               busy,
  output logic               blk_done,
  output logic               blk_fail,
  output logic               crc_err,
  output logic               irq
);

  localparam int LANES  = 2;
  localparam int DAT_W  = BYTES_W + 3;
  localparam int CRC_CW = $clog2(LANES * CRC_W);
  localparam int BITS_W = (DAT_W > CRC_CW) ? DAT_W : CRC_CW;
  localparam logic [BITS_W-1:0] LAST_SDR = BITS_W'(CRC_W - 1);
  localparam logic [BITS_W-1:0] LAST_DDR = BITS_W'(LANES * CRC_W - 1);

  blk_state_e        state_q;
  logic              ddr_q;
  logic [BITS_W-1:0] nbits_q;
  logic [BITS_W-1:0] cnt_q;
  logic              sel_q;
  logic              mism_q;

  logic [LANES-1:0]  lane_msb;
  lane_op_e          lane_op [LANES];
  lane_op_e          cur_op;
  logic              lane_din;
  logic              cur_msb;
  logic [BITS_W-1:0] crc_last;
  logic              sel_nxt;
  logic              data_last;
  logic              crc_end;
  logic              done_set;
  logic              fail_set;
  logic              tok_done;
  logic              tok_good;

  assign cur_msb   = lane_msb[sel_q];
  assign crc_last  = ddr_q ? LAST_DDR : LAST_SDR;
  assign sel_nxt   = ddr_q ? ~sel_q : 1'b0;
  assign data_last = (cnt_q == nbits_q - 1'b1);
  assign crc_end   = (cnt_q == crc_last);
  assign busy      = (state_q != ST_IDLE);

  // Operation applied to the active lane this cycle
  always_comb begin
    cur_op   = LOP_HOLD;
    lane_din = 1'b0;
    case (state_q)
      ST_IDLE:    if (start_rd || start_wr) cur_op = LOP_INIT;
      ST_RD_DATA: if (rx_vld) begin cur_op = LOP_FEED; lane_din = rx_bit; end
      ST_RD_CRC:  if (rx_vld) cur_op = LOP_SHIFT;
      ST_WR_DATA: if (wr_vld) begin cur_op = LOP_FEED; lane_din = wr_bit; end
      ST_WR_CRC:  cur_op = LOP_SHIFT;
      default:    cur_op = LOP_HOLD;
    endcase
  end

  // Completion and failure decided in the cycle the last bit is seen
  always_comb begin
    done_set = 1'b0;
    fail_set = 1'b0;
    if (state_q == ST_RD_CRC && rx_vld && crc_end) begin
      done_set = 1'b1;
      fail_set = mism_q || (rx_bit != cur_msb);
    end else if (state_q == ST_WR_TOK && tok_done) begin
      done_set = 1'b1;
      fail_set = !tok_good;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam logic LSEL = 1'(l);
    assign lane_op[l] = (cur_op == LOP_INIT) ? LOP_INIT :
                        (sel_q == LSEL)      ? cur_op   : LOP_HOLD;
    sdcrc_lane #(.CRC_W(CRC_W), .POLY(CRC_POLY)) lane_i (
      .clk (clk),
      .rst (rst),
      .op  (lane_op[l]),
      .din (lane_din),
      .msb (lane_msb[l])
    );
  end

  sdcrc_tok #(.TOK_W(TOK_W), .GOOD(TOK_GOOD)) tok_i (
    .clk    (clk),
    .rst    (rst),
    .en     (state_q == ST_WR_TOK),
    .vld    (rx_vld),
    .bit_in (rx_bit),
    .done   (tok_done),
    .good   (tok_good)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ddr_q   <= 1'b0;
      nbits_q <= '0;
      cnt_q   <= '0;
      sel_q   <= 1'b0;
      mism_q  <= 1'b0;
      tx_vld  <= 1'b0;
      tx_bit  <= 1'b0;
    end else begin
      tx_vld <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (start_rd || start_wr) begin
            state_q <= start_rd ? ST_RD_DATA : ST_WR_DATA;
            ddr_q   <= ddr_mode;
            nbits_q <= BITS_W'({blk_bytes, 3'b000});
            cnt_q   <= '0;
            sel_q   <= 1'b0;
            mism_q  <= 1'b0;
          end
        end
        ST_RD_DATA: begin
          if (rx_vld) begin
            sel_q <= sel_nxt;
            if (data_last) begin
              cnt_q   <= '0;
              state_q <= ST_RD_CRC;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_RD_CRC: begin
          if (rx_vld) begin
            sel_q  <= sel_nxt;
            mism_q <= mism_q || (rx_bit != cur_msb);
            if (crc_end) state_q <= ST_IDLE;
            else         cnt_q   <= cnt_q + 1'b1;
          end
        end
        ST_WR_DATA: begin
          if (wr_vld) begin
            tx_vld <= 1'b1;
            tx_bit <= wr_bit;
            sel_q  <= sel_nxt;
            if (data_last) begin
              cnt_q   <= '0;
              state_q <= ST_WR_CRC;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        ST_WR_CRC: begin
          tx_vld <= 1'b1;
          tx_bit <= cur_msb;
          sel_q  <= sel_nxt;
          if (crc_end) begin
            cnt_q   <= '0;
            state_q <= ST_WR_TOK;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WR_TOK: begin
          if (tok_done) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Status outputs
  always_ff @(posedge clk) begin
    if (rst) begin
      blk_done <= 1'b0;
      blk_fail <= 1'b0;
      crc_err  <= 1'b0;
      irq      <= 1'b0;
    end else begin
      blk_done <= done_set;
      blk_fail <= fail_set;
      if (fail_set)     crc_err <= 1'b1;
      else if (clr_err) crc_err <= 1'b0;
      irq <= crc_err && irq_en;
    end
  end

  AST_FAIL_NEEDS_DONE: assert property (@(posedge clk) disable iff (rst)
    blk_fail |-> blk_done); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    blk_done |=> !blk_done); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (crc_err && !clr_err) |=> crc_err); // R5
  AST_FAIL_FLAGS_ERR: assert property (@(posedge clk) disable iff (rst)
    blk_fail |-> crc_err); // R5
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    !irq_en |=> !irq); // R6
  AST_TX_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
    tx_vld |-> busy); // R3
  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (rst)
    (!busy && (start_rd || start_wr)) |->
      (blk_bytes != '0 && blk_bytes <= BYTES_W'(MAX_BYTES))); // R7

endmodule

// File: tb/sdcrc_unit_tb_top.sv
`timescale 1ns/1ps
module sdcrc_unit_tb_top;

  localparam int MAX_BYTES = 512;
  localparam int BYTES_W   = $clog2(MAX_BYTES + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_rd = 0, start_wr = 0, ddr_mode = 0;
  logic [BYTES_W-1:0] blk_bytes = '0;
  logic rx_vld = 0, rx_bit = 1, wr_vld = 0, wr_bit = 0;
  logic clr_err = 0, irq_en = 1;
  logic tx_vld, tx_bit, busy, blk_done, blk_fail, crc_err, irq;

  always #2.5 clk = ~clk;

  sdcrc_unit #(.MAX_BYTES(MAX_BYTES)) dut_i (
    .clk(clk), .rst(rst), .start_rd(start_rd), .start_wr(start_wr),
    .ddr_mode(ddr_mode), .blk_bytes(blk_bytes), .rx_vld(rx_vld),
    .rx_bit(rx_bit), .wr_vld(wr_vld), .wr_bit(wr_bit), .clr_err(clr_err),
    .irq_en(irq_en), .tx_vld(tx_vld), .tx_bit(tx_bit), .busy(busy),
    .blk_done(blk_done), .blk_fail(blk_fail), .crc_err(crc_err), .irq(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit [7:0] blk [0:63];
  bit cap [0:1023];
  int cap_n = 0;

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected below 150000", cycles);
      summary();
    end
  end

  always @(negedge clk) if (tx_vld && cap_n < 1024) begin
    cap[cap_n] = tx_bit;
    cap_n++;
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_crc(int n, bit ddr, int lane);
    logic [15:0] c = '0;
    for (int i = 0; i < n * 8; i++) begin
      bit b = blk[i / 8][7 - (i % 8)];
      if (!ddr || (i % 2) == lane) begin
        bit fb = c[15] ^ b;
        c = {c[14:0], 1'b0};
        if (fb) c = c ^ 16'h1021;
      end
    end
    return c;
  endfunction

  function automatic bit line_bit(int n, bit ddr, int j);
    int k;
    logic [15:0] c;
    if (j < n * 8) return blk[j / 8][7 - (j % 8)];
    k = j - n * 8;
    if (!ddr) begin
      c = ref_crc(n, 1'b0, 0);
      return c[15 - k];
    end
    c = ref_crc(n, 1'b1, k % 2);
    return c[15 - k / 2];
  endfunction

  task automatic fill(int n);
    for (int i = 0; i < n; i++) blk[i] = 8'($urandom);
  endtask

  task automatic wait_done(output bit got, output bit fail);
    got = 0;
    fail = 0;
    for (int i = 0; i < 12 && !got; i++) begin
      rx_vld = 0;
      wr_vld = 0;
      if (blk_done) begin
        got = 1;
        fail = blk_fail;
      end else begin
        @(negedge clk);
      end
    end
  endtask

  task automatic do_read(int n, bit ddr, int flip, bit gaps, bit poke,
                         output bit got, output bit fail);
    int total = n * 8 + (ddr ? 32 : 16);
    @(negedge clk);
    blk_bytes = BYTES_W'(n);
    ddr_mode = ddr;
    start_rd = 1;
    @(negedge clk);
    start_rd = 0;
    for (int j = 0; j < total; j++) begin
      if (poke && j == 5) begin
        rx_vld = 0;
        start_wr = 1;
        start_rd = 1;
        blk_bytes = BYTES_W'(n + 3);
        ddr_mode = ~ddr;
        @(negedge clk);
        start_wr = 0;
        start_rd = 0;
      end
      if (gaps && ($urandom % 4) == 0) begin
        rx_vld = 0;
        @(negedge clk);
      end
      rx_vld = 1;
      rx_bit = line_bit(n, ddr, j) ^ (j == flip);
      @(negedge clk);
    end
    wait_done(got, fail);
  endtask

  task automatic do_write(int n, bit ddr, logic [2:0] tok, bit endb, int idle,
                          bit gaps, output bit got, output bit fail,
                          output int tx_bad);
    int total = n * 8 + (ddr ? 32 : 16);
    cap_n = 0;
    @(negedge clk);
    blk_bytes = BYTES_W'(n);
    ddr_mode = ddr;
    start_wr = 1;
    @(negedge clk);
    start_wr = 0;
    for (int j = 0; j < n * 8; j++) begin
      if (gaps && ($urandom % 4) == 0) begin
        wr_vld = 0;
        @(negedge clk);
      end
      wr_vld = 1;
      wr_bit = line_bit(n, ddr, j);
      @(negedge clk);
    end
    wr_vld = 0;
    for (int t = 0; t < 200 && cap_n < total; t++) begin
      @(negedge clk);
      #1;
    end
    tx_bad = (cap_n == total) ? 0 : 1000;
    for (int j = 0; j < total && j < cap_n; j++)
      if (cap[j] != line_bit(n, ddr, j)) tx_bad++;
    @(negedge clk);
    for (int i = 0; i < idle; i++) begin
      rx_vld = 1; rx_bit = 1; @(negedge clk);
    end
    rx_vld = 1; rx_bit = 0;      @(negedge clk);
    rx_bit = tok[2];             @(negedge clk);
    rx_bit = tok[1];             @(negedge clk);
    rx_bit = tok[0];             @(negedge clk);
    rx_bit = endb;               @(negedge clk);
    wait_done(got, fail);
  endtask

  task automatic clear_err();
    @(negedge clk);
    clr_err = 1;
    @(negedge clk);
    clr_err = 0;
  endtask

  task automatic post_checks(string req, bit got, bit fail, bit exp_fail);
    chk(req, "blk_done", 32'(got), 1);
    chk(req, "blk_fail", 32'(fail), 32'(exp_fail));
    chk("R5", "crc_err", 32'(crc_err), 32'(exp_fail));
    @(negedge clk);
    chk("R9", "blk_done pulse", 32'(blk_done), 0);
    chk("R6", "irq", 32'(irq), 32'(exp_fail & irq_en));
  endtask

  initial begin
    bit got, fail;
    int txb;
    void'($urandom(32'h5EED_0C2C));
    repeat (4) @(negedge clk);
    // R8: reset state
    chk("R8", "busy", 32'(busy), 0);
    chk("R8", "tx_vld", 32'(tx_vld), 0);
    chk("R8", "blk_done", 32'(blk_done), 0);
    chk("R8", "crc_err", 32'(crc_err), 0);
    chk("R8", "irq", 32'(irq), 0);
    rst = 0;
    @(negedge clk);

    // R1: single-rate read, shortest block, good then corrupted check bit
    fill(1);
    do_read(1, 0, -1, 0, 0, got, fail);
    post_checks("R1", got, fail, 0);
    fill(4);
    do_read(4, 0, 4 * 8 + 15, 0, 0, got, fail);
    post_checks("R1", got, fail, 1);
    clear_err();
    chk("R5", "crc_err after clear", 32'(crc_err), 0);

    // R2: double-rate read, good, falling-lane check bit flipped, falling data bit flipped
    fill(5);
    do_read(5, 1, -1, 1, 0, got, fail);
    post_checks("R2", got, fail, 0);
    do_read(5, 1, 5 * 8 + 1, 0, 0, got, fail);
    post_checks("R2", got, fail, 1);
    clear_err();
    do_read(5, 1, 7, 0, 0, got, fail);
    post_checks("R2", got, fail, 1);
    clear_err();

    // R3/R4: writes with token variants
    fill(3);
    do_write(3, 0, 3'b010, 1, 0, 0, got, fail, txb);
    chk("R3", "tx stream sdr", 32'(txb), 0);
    post_checks("R4", got, fail, 0);
    do_write(3, 1, 3'b010, 1, 6, 1, got, fail, txb);
    chk("R3", "tx stream ddr", 32'(txb), 0);
    post_checks("R4", got, fail, 0);
    do_write(3, 0, 3'b101, 1, 2, 0, got, fail, txb);
    post_checks("R4", got, fail, 1);
    clear_err();
    do_write(2, 1, 3'b011, 1, 1, 0, got, fail, txb);
    post_checks("R4", got, fail, 1);
    clear_err();
    do_write(2, 0, 3'b010, 0, 0, 0, got, fail, txb);
    post_checks("R4", got, fail, 1);

    // R5: flag stays set across a good block until cleared
    fill(2);
    do_read(2, 0, -1, 0, 0, got, fail);
    chk("R5", "sticky across good block", 32'(crc_err), 1);
    clear_err();
    chk("R5", "cleared", 32'(crc_err), 0);

    // R6: masked interrupt, then unmasked
    irq_en = 0;
    do_read(2, 0, 3, 0, 0, got, fail);
    post_checks("R6", got, fail, 1);
    @(negedge clk);
    chk("R6", "irq masked", 32'(irq), 0);
    irq_en = 1;
    @(negedge clk);
    chk("R6", "irq unmasked", 32'(irq), 1);
    clear_err();
    @(negedge clk);
    chk("R6", "irq after clear", 32'(irq), 0);

    // R7: starts and config changes ignored while busy
    fill(2);
    cap_n = 0;
    do_read(2, 0, -1, 0, 1, got, fail);
    post_checks("R7", got, fail, 0);
    chk("R7", "no write started", 32'(cap_n), 0);
    chk("R7", "idle after block", 32'(busy), 0);

    // Random mix
    for (int it = 0; it < 24; it++) begin
      int n = 1 + int'($urandom % 6);
      bit ddr = 1'($urandom);
      bit ef;
      fill(n);
      if ($urandom % 2) begin
        int tot = n * 8 + (ddr ? 32 : 16);
        int fl = ($urandom % 2) ? int'($urandom % tot) : -1;
        do_read(n, ddr, fl, 1, 0, got, fail);
        ef = (fl >= 0);
        post_checks(ddr ? "R2" : "R1", got, fail, ef);
      end else begin
        logic [2:0] tk = ($urandom % 2) ? 3'b010 : 3'($urandom);
        bit eb = ($urandom % 8) != 0;
        do_write(n, ddr, tk, eb, int'($urandom % 4), 1, got, fail, txb);
        ef = !(tk == 3'b010 && eb);
        chk("R3", "tx stream", 32'(txb), 0);
        post_checks("R4", got, fail, ef);
      end
      clear_err();
    end

    summary();
  end

endmodule